// File: doc/BRIEF.md
# Real-Time Clock Interrupt Pin Controller

This block gathers three event sources of a timekeeping device (a watchdog timeout, an alarm match and a supply-loss warning) into one configurable interrupt output. Every event latches a sticky flag. A programmable enable byte chooses which of the flagged sources may also raise the pin. The pin signals either as an active-high push-pull output or as an active-low open-drain output. It can signal either with a pulse of fixed length or with a level that stays until the host reads the flags.

A host finds the cause of an interrupt by strobing a flag read. The read returns the latched flags and clears them, and it also releases the pin. In backup-supply mode only open-drain signalling is possible, and only the alarm can raise the pin, and only when a separate backup enable permits it. A cold start loads a preset that arms the supply-loss source as an active-low pulse. A warm reset keeps the stored configuration.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: Each event input sets its own flag whatever the configuration. `flag_rdata` shows bit 2 for the watchdog, bit 1 for the alarm and bit 0 for supply loss, and each flag stays set until a read.
- R2: A source raises the pin only when its enable bit is 1: bit 7 for the watchdog, bit 6 for the alarm, bit 5 for supply loss. An event from a disabled source leaves the pin inactive.
- R3: Configuration bit 3 selects the polarity. When it is 1 and main power is present, `int_oe` is always 1 and `int_val` is 1 while the pin is asserted and 0 while idle. When it is 0, an asserted pin gives `int_oe`=1 and `int_val`=0, and an idle pin gives `int_oe`=0.
- R4: With bit 2 = 1 (pulse mode), a qualifying event asserts the pin from the next cycle for exactly `PULSE_CYC` cycles.
- R5: With bit 2 = 0 (level mode), a qualifying event asserts the pin from the next cycle until a flag read.
- R6: A flag read (`flag_rd` high for one cycle) presents the flags on `flag_rdata` in that cycle. From the next cycle every flag is zero and the pin is inactive, which also ends a running pulse early.
- R7: An event that arrives in the same cycle as a flag read is kept. Its flag is set after the read, and if it qualifies the pin is asserted in the next cycle.
- R8: A qualifying event during an active pulse does not restart the pulse. The pin still drops `PULSE_CYC` cycles after the pulse began.
- R9: While `on_battery` is 1, the watchdog and supply-loss events never raise the pin. The alarm raises it only if bits 6 and 4 are both 1 and bit 3 is 0.
- R10: While `on_battery` is 1 and bit 3 is 1, the pin is released (`int_oe`=0).
- R11: With main power present, an enabled supply-loss event raises the pin whether bit 4 is 0 or 1.
- R12: A reset with `cold_start` high loads the configuration 8'h24. A reset with `cold_start` low keeps the stored configuration. Both kinds of reset clear the flags and release the pin state.
- R13: Configuration bits 1 and 0 always read back as zero on `cfg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cold_start | input | 1 | During reset: load the preset configuration (no backup supply) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored configuration |
| flag_rd | input | 1 | Flag read strobe; clears the flags and the pin |
| flag_rdata | output | 3 | Latched flags {watchdog, alarm, supply loss} |
| ev_wdog | input | 1 | Watchdog timeout event |
| ev_alarm | input | 1 | Alarm match event |
| ev_pfail | input | 1 | Supply-loss warning event |
| on_battery | input | 1 | Backup-supply mode |
| int_val | output | 1 | Interrupt pin value |
| int_oe | output | 1 | Interrupt pin drive enable |

## Verification
The assertions assume a synchronous reset whose first active edge comes before any event, and event inputs that are sampled once per cycle, so an event held high for several cycles counts as several events. They also assume a cold reset is applied before any warm reset, so the stored configuration is never undefined. The stimulus changes every input only on the falling clock edge. It applies a cold reset first and holds each event for exactly one cycle. It switches the backup mode and the configuration only between interrupt episodes, so a pulse never spans a change of mode.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int NSRC   = 3;
    localparam int SRC_PF = 0;
    localparam int SRC_AL = 1;
    localparam int SRC_WD = 2;

    typedef struct packed {
        logic       wd_en;
        logic       al_en;
        logic       pf_en;
        logic       al_batt;
        logic       pol_hi;
        logic       pulse;
        logic [1:0] rsv;
    } irq_cfg_t;

    localparam logic [7:0] CFG_COLD  = 8'h24;
    localparam logic [7:0] CFG_WMASK = 8'hFC;
endpackage

// File: rtl/rtc_irq_cfg.sv
module rtc_irq_cfg
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cold_i,
    input  logic       we_i,
    input  logic [7:0] wdata_i,
    output irq_cfg_t   cfg_o
);
    typedef struct packed {
        irq_cfg_t cfg;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            if (cold_i)
                st_d.cfg = irq_cfg_t'(CFG_COLD);
        end else if (we_i) begin
            st_d.cfg = irq_cfg_t'(wdata_i & CFG_WMASK);
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign cfg_o = st_q.cfg;

    p_write_lands_r13: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (cfg_o[7:2] == $past(wdata_i[7:2])) && (cfg_o[1:0] == 2'b00));
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
    parameter int NS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] ev_i,
    input  logic          rd_i,
    input  logic [NS-1:0] en_i,
    input  logic          batt_i,
    input  logic [NS-1:0] batt_ok_i,
    output logic [NS-1:0] flags_o,
    output logic          qual_o
);
    typedef struct packed {
        logic [NS-1:0] flags;
    } st_t;

    st_t           st_q, st_d;
    logic [NS-1:0] allow;

    always_comb begin
        allow  = batt_i ? (en_i & batt_ok_i) : en_i;
        qual_o = |(ev_i & allow);
        st_d   = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else begin
            for (int i = 0; i < NS; i++)
                st_d.flags[i] = (st_q.flags[i] & ~rd_i) | ev_i[i];
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign flags_o = st_q.flags;

    p_event_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((flags_o & $past(ev_i)) == $past(ev_i)));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && ev_i == '0) |=> (flags_o == '0));

    p_flag_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

// File: rtl/rtc_irq_pin.sv
module rtc_irq_pin #(
    parameter int PULSE_CYC = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_i,
    input  logic rd_i,
    input  logic pulse_i,
    input  logic pol_hi_i,
    input  logic batt_i,
    output logic oe_o,
    output logic val_o
);
    localparam int             CW      = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0]  PULSE_LD = CW'(PULSE_CYC);

    typedef struct packed {
        logic          arm;
        logic [CW-1:0] cnt;
    } st_t;

    st_t  st_q, st_d;
    logic active;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else begin
            st_d.arm = rd_i ? qual_i : (st_q.arm | qual_i);
            if (rd_i || st_q.cnt == '0)
                st_d.cnt = qual_i ? PULSE_LD : '0;
            else
                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    always_comb begin
        active = pulse_i ? (st_q.cnt != '0) : st_q.arm;
        if (batt_i) begin
            oe_o  = active & ~pol_hi_i;
            val_o = 1'b0;
        end else if (pol_hi_i) begin
            oe_o  = 1'b1;
            val_o = active;
        end else begin
            oe_o  = active;
            val_o = 1'b0;
        end
    end

    p_pulse_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0 && !rd_i) |=> (st_q.cnt == CW'($past(st_q.cnt) - 1'b1)));

    p_read_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !qual_i) |=> !active);

    p_open_drain_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pol_hi_i && oe_o) |-> !val_o);

    p_batt_no_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        batt_i |-> !(oe_o && val_o));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int PULSE_CYC = 10_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cold_start,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       flag_rd,
    output logic [2:0] flag_rdata,
    input  logic       ev_wdog,
    input  logic       ev_alarm,
    input  logic       ev_pfail,
    input  logic       on_battery,
    output logic       int_val,
    output logic       int_oe
);
    irq_cfg_t        cfg;
    logic [NSRC-1:0] ev_vec, en_vec, batt_ok, flags;
    logic            qual;

    rtc_irq_cfg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cold_i  (cold_start),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg)
    );

    always_comb begin
        ev_vec          = '0;
        en_vec          = '0;
        batt_ok         = '0;
        ev_vec[SRC_WD]  = ev_wdog;
        ev_vec[SRC_AL]  = ev_alarm;
        ev_vec[SRC_PF]  = ev_pfail;
        en_vec[SRC_WD]  = cfg.wd_en;
        en_vec[SRC_AL]  = cfg.al_en;
        en_vec[SRC_PF]  = cfg.pf_en;
        batt_ok[SRC_AL] = cfg.al_batt & ~cfg.pol_hi;
    end

    rtc_irq_flags #(.NS(NSRC)) i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev_vec),
        .rd_i      (flag_rd),
        .en_i      (en_vec),
        .batt_i    (on_battery),
        .batt_ok_i (batt_ok),
        .flags_o   (flags),
        .qual_o    (qual)
    );

    rtc_irq_pin #(.PULSE_CYC(PULSE_CYC)) i_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual_i   (qual),
        .rd_i     (flag_rd),
        .pulse_i  (cfg.pulse),
        .pol_hi_i (cfg.pol_hi),
        .batt_i   (on_battery),
        .oe_o     (int_oe),
        .val_o    (int_val)
    );

    assign cfg_rdata  = cfg;
    assign flag_rdata = flags;

    p_batt_wdog_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (on_battery && ev_wdog && !ev_alarm && !ev_pfail && !flag_rd && !int_oe)
        |=> !int_oe);

    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && cfg.wd_en == 1'b0 && cfg.al_en == 1'b0 && cfg.pf_en == 1'b0
         && !cfg.pol_hi && !int_oe) |=> !int_oe);
endmodule

// File: tb/test_rtc_irq_ctrl.sv
module test_rtc_irq_ctrl;
    localparam int PW = 6;

    logic       clk = 1'b0;
    logic       rst_n, cold_start, cfg_we, flag_rd;
    logic       ev_wdog, ev_alarm, ev_pfail, on_battery;
    logic [7:0] cfg_wdata, cfg_rdata;
    logic [2:0] flag_rdata;
    logic       int_val, int_oe;

    always #10 clk = ~clk;

    rtc_irq_ctrl #(.PULSE_CYC(PW)) i_rtc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cold_start(cold_start),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .flag_rd(flag_rd), .flag_rdata(flag_rdata),
        .ev_wdog(ev_wdog), .ev_alarm(ev_alarm), .ev_pfail(ev_pfail),
        .on_battery(on_battery), .int_val(int_val), .int_oe(int_oe)
    );

    typedef struct {
        logic  oe;
        logic  val;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;

    // monitor: pops one expected pin state per driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (int_oe !== e.oe || int_val !== e.val) begin
                    fails++;
                    $display("FAIL %s pin: actual oe=%b val=%b expected oe=%b val=%b",
                             e.req, int_oe, int_val, e.oe, e.val);
                end
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s value: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input logic wd, input logic al, input logic pf, input logic rd,
                        input logic eoe, input logic evl, input string req);
        ev_wdog  = wd;
        ev_alarm = al;
        ev_pfail = pf;
        flag_rd  = rd;
        q.push_back('{eoe, evl, req});
        @(negedge clk);
        ev_wdog  = 1'b0;
        ev_alarm = 1'b0;
        ev_pfail = 1'b0;
        flag_rd  = 1'b0;
    endtask

    task automatic idle(input int n, input logic eoe, input logic evl, input string req);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, eoe, evl, req);
    endtask

    task automatic wcfg(input logic [7:0] d, input logic eoe, input logic evl, input string req);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        q.push_back('{eoe, evl, req});
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset(input logic cold);
        rst_n      = 1'b0;
        cold_start = cold;
        repeat (3) @(negedge clk);
        rst_n      = 1'b1;
        cold_start = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; cold_start = 1; cfg_we = 0; cfg_wdata = '0; flag_rd = 0;
        ev_wdog = 0; ev_alarm = 0; ev_pfail = 0; on_battery = 0;
        @(negedge clk);
        do_reset(1'b1);
        chk(cfg_rdata, 8'h24, "R12 cold preset");
        chk({5'd0, flag_rdata}, 8'h00, "R12 flags cleared");
        idle(1, 0, 0, "R12 pin idle after reset");

        // preset: supply loss enabled, active-low pulse
        tick(0, 0, 1, 0, 1, 0, "R4 pulse start");
        idle(PW - 1, 1, 0, "R4 pulse body");
        idle(1, 0, 0, "R4 pulse end");
        chk({5'd0, flag_rdata}, 8'h01, "R1 supply-loss flag");
        tick(0, 0, 0, 1, 0, 0, "R6 read");
        chk({5'd0, flag_rdata}, 8'h00, "R6 flags cleared");

        tick(0, 0, 1, 0, 1, 0, "R6 pulse start");
        idle(2, 1, 0, "R6 pulse body");
        tick(0, 0, 0, 1, 0, 0, "R6 read cuts pulse");
        idle(1, 0, 0, "R6 stays released");

        tick(0, 0, 1, 0, 1, 0, "R8 pulse start");
        idle(2, 1, 0, "R8 pulse body");
        tick(0, 0, 1, 0, 1, 0, "R8 second event");
        idle(2, 1, 0, "R8 pulse body");
        idle(1, 0, 0, "R8 no restart");
        tick(0, 0, 0, 1, 0, 0, "R8 read");

        tick(1, 0, 0, 0, 0, 0, "R2 watchdog disabled");
        chk({5'd0, flag_rdata}, 8'h04, "R1 watchdog flag");
        tick(0, 1, 0, 0, 0, 0, "R2 alarm disabled");
        chk({5'd0, flag_rdata}, 8'h06, "R1 alarm flag");
        tick(0, 0, 0, 1, 0, 0, "R6 read");

        // level, push-pull, watchdog + alarm enabled
        wcfg(8'hC8, 1, 0, "R3 push-pull idle");
        chk(cfg_rdata, 8'hC8, "R3 cfg stored");
        tick(0, 1, 0, 0, 1, 1, "R5 level assert");
        idle(PW + 2, 1, 1, "R5 level held");
        tick(0, 1, 0, 1, 1, 1, "R7 event with read");
        chk({5'd0, flag_rdata}, 8'h02, "R7 flag kept");
        tick(0, 0, 0, 1, 1, 0, "R6 read releases level");
        chk({5'd0, flag_rdata}, 8'h00, "R6 flags cleared");
        tick(0, 0, 1, 0, 1, 0, "R2 supply loss disabled");
        tick(0, 0, 0, 1, 1, 0, "R6 read");
        tick(1, 0, 0, 0, 1, 1, "R2 watchdog enabled");
        tick(0, 0, 0, 1, 1, 0, "R6 read");

        // backup mode
        on_battery = 1'b1;
        idle(1, 0, 0, "R10 released in backup");
        tick(0, 1, 0, 0, 0, 0, "R10 alarm push-pull backup");
        tick(0, 0, 0, 1, 0, 0, "R6 read");
        wcfg(8'hF0, 0, 0, "R9 cfg open-drain level");
        tick(1, 0, 0, 0, 0, 0, "R9 watchdog blocked");
        tick(0, 0, 1, 0, 0, 0, "R9 supply loss blocked");
        chk({5'd0, flag_rdata}, 8'h05, "R1 flags in backup");
        tick(0, 0, 0, 1, 0, 0, "R6 read");
        tick(0, 1, 0, 0, 1, 0, "R9 alarm allowed");
        idle(1, 1, 0, "R9 alarm held");
        tick(0, 0, 0, 1, 0, 0, "R6 read");
        wcfg(8'hE0, 0, 0, "R9 cfg no backup enable");
        tick(0, 1, 0, 0, 0, 0, "R9 alarm blocked");
        tick(0, 0, 0, 1, 0, 0, "R6 read");

        on_battery = 1'b0;
        wcfg(8'h20, 0, 0, "R11 cfg");
        tick(0, 0, 1, 0, 1, 0, "R11 supply loss no backup enable");
        tick(0, 0, 0, 1, 0, 0, "R6 read");
        wcfg(8'h30, 0, 0, "R11 cfg");
        tick(0, 0, 1, 0, 1, 0, "R11 supply loss with backup enable");
        tick(0, 0, 0, 1, 0, 0, "R6 read");

        wcfg(8'hFF, 1, 0, "R13 cfg all ones");
        chk(cfg_rdata, 8'hFC, "R13 reserved bits zero");

        wcfg(8'hF8, 1, 0, "R12 cfg before warm reset");
        tick(0, 1, 0, 0, 1, 1, "R12 level asserted");
        do_reset(1'b0);
        chk(cfg_rdata, 8'hF8, "R12 warm reset keeps cfg");
        chk({5'd0, flag_rdata}, 8'h00, "R12 warm reset clears flags");
        idle(1, 1, 0, "R12 warm reset releases pin");
        do_reset(1'b1);
        chk(cfg_rdata, 8'h24, "R12 cold reset preset");
        idle(1, 0, 0, "R12 cold reset pin idle");

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule